// File: doc/BRIEF.md
# Atomic Swap Lock Unit with Round-Robin Bus Arbitration

This block sits on the memory side of a single shared bus that several processors use. It holds a small array of lock words. Each processor raises a request that carries an operation, a lock index and write data, and keeps it raised until it is granted. A round-robin arbiter grants one requester per cycle, and that granted cycle is the whole bus operation. The read of the lock word and any write to it happen at the same clock edge, so no other access can come between them.

Three operations are available. A load returns the word. A store overwrites the word with the request data, and a store of 0 releases a lock. A swap returns the word and leaves 1 in it. A processor waits by loading a lock until it reads 0. It then tries a swap, and it owns the lock only if the swap returns 0. When several processors contend for the same lock, the arbiter puts them in order. Exactly one of them sees 0, and the rest see the 1 that the winner left behind.

Every granted operation produces one response in the following cycle. The response carries the id of the requester and the value the word held before the operation.

Top module: `swap_lock_unit`

## Requirements
- R1: Operation code 2'b10 (swap) returns the value the addressed word held before the operation and leaves the value 1 in that word, with no other access in between.
- R2: At most one bit of `grant` is set in any cycle. A bit is set only for a requester whose `req_valid` is high, and some bit is set whenever any `req_valid` is high.
- R3: Priority rotates round-robin. The search starts at the requester after the one granted last. After reset, requester 0 has the highest priority.
- R4: A requester granted in one cycle is not granted in the next cycle while any other requester is waiting. No requester starves.
- R5: When several swaps target a lock that holds 0, exactly one of them returns 0. All later ones return 1 until a store writes 0 to the lock again.
- R6: `rsp_valid` is high exactly in the cycle after a grant. In that cycle `rsp_id` gives the granted requester and `rsp_data` gives the word value before its operation.
- R7: Operation code 2'b01 (store) writes `req_wdata` into the word. A store of 0 releases the lock, so the next swap on that lock returns 0.
- R8: Operation codes 2'b00 and 2'b11 (load) return the word and leave it unchanged.
- R9: A store and a swap that target the same word in the same cycle are carried out one after the other, in grant order. The word ends with the value written by the one granted second.
- R10: Reset clears every lock word to 0 and holds `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | One request line per processor, held until granted |
| req_op | input | 2*NUM_REQ | Operation per processor: 00 load, 01 store, 10 swap, 11 load |
| req_addr | input | NUM_REQ*ADDR_W | Lock index per processor |
| req_wdata | input | NUM_REQ*DATA_W | Store data per processor |
| grant | output | NUM_REQ | One-hot grant for the current cycle |
| rsp_valid | output | 1 | Response pulse, one cycle after a grant |
| rsp_id | output | ID_W | Requester that the response belongs to |
| rsp_data | output | DATA_W | Word value before the granted operation |

## Verification
The unit is first driven with requests from one processor at a time. These show the value returned by each operation and the state each operation leaves behind. Swaps from all processors in the same cycle on a free lock test whether exactly one of them wins, and whether the reset priority decides which one. Stores and swaps on the same lock in the same cycle are run from two different priority positions, so the final word shows that grant order is kept and that the two operations are never merged. A free-running phase follows, in which every processor loads until the lock reads 0, swaps, holds the lock and releases it. This phase checks mutual exclusion and checks that the rotation lets every processor acquire the lock.

// File: rtl/swap_lock_pkg.sv
package swap_lock_pkg;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'b00,
        OP_STORE    = 2'b01,
        OP_SWAP     = 2'b10,
        OP_LOAD_ALT = 2'b11
    } lock_op_e;

    function automatic logic op_writes(input lock_op_e op);
        return (op == OP_STORE) || (op == OP_SWAP);
    endfunction

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt,
    output logic [IDX_W-1:0]   gnt_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] last;
    } arb_state_t;

    arb_state_t st_d, st_q;

    always_comb begin
        int   pos;
        logic found;
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        pos     = 0;
        for (int k = 1; k <= NUM_REQ; k++) begin
            pos = (int'(st_q.last) + k) % NUM_REQ;
            if (!found && req[pos]) begin
                found    = 1'b1;
                gnt[pos] = 1'b1;
                gnt_idx  = IDX_W'(pos);
            end
        end
        if (found) begin
            st_d.last = gnt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= IDX_W'(NUM_REQ - 1);
        end else begin
            st_q <= st_d;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2
    AST_GRANT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R2
    AST_GRANT_IF_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0)); // R2
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |=> (((req & ~$past(gnt)) == '0) || ((gnt & $past(gnt)) == '0))); // R4

endmodule

// File: rtl/req_select.sv
module req_select
    import swap_lock_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [2*NUM_REQ-1:0]      req_op,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    input  logic [IDX_W-1:0]          sel_idx,
    output lock_op_e                  sel_op,
    output logic [ADDR_W-1:0]         sel_addr,
    output logic [DATA_W-1:0]         sel_wdata
);

    logic [NUM_REQ-1:0][1:0]        op_arr;
    logic [NUM_REQ-1:0][ADDR_W-1:0] addr_arr;
    logic [NUM_REQ-1:0][DATA_W-1:0] wdata_arr;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_slice
        assign op_arr[g]    = req_op[2*g +: 2];
        assign addr_arr[g]  = req_addr[ADDR_W*g +: ADDR_W];
        assign wdata_arr[g] = req_wdata[DATA_W*g +: DATA_W];
    end

    always_comb begin
        sel_op    = lock_op_e'(op_arr[sel_idx]);
        sel_addr  = addr_arr[sel_idx];
        sel_wdata = wdata_arr[sel_idx];
    end

endmodule

// File: rtl/lock_store.sv
module lock_store
    import swap_lock_pkg::*;
#(
    parameter int NUM_LOCKS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  lock_op_e          op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] old_data
);

    typedef struct packed {
        logic [NUM_LOCKS-1:0][DATA_W-1:0] words;
    } store_state_t;

    store_state_t st_d, st_q;
    logic         in_range;

    always_comb begin
        st_d     = st_q;
        in_range = (int'(addr) < NUM_LOCKS);
        old_data = in_range ? st_q.words[addr] : '0;
        if (op_en && in_range && op_writes(op)) begin
            if (op == OP_SWAP) begin
                st_d.words[addr] = DATA_W'(1);
            end else begin
                st_d.words[addr] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SWAP_LEAVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == OP_SWAP) |=> (st_q.words[$past(addr)] == DATA_W'(1))); // R1
    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op == OP_STORE) |=> (st_q.words[$past(addr)] == $past(wdata))); // R7
    AST_LOAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && !op_writes(op)) |=> $stable(st_q.words)); // R8
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(st_q.words)); // R1

endmodule

// File: rtl/swap_lock_unit.sv
module swap_lock_unit
    import swap_lock_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int NUM_LOCKS = 8,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1,
    localparam int ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [2*NUM_REQ-1:0]      req_op,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    output logic [NUM_REQ-1:0]        grant,
    output logic                      rsp_valid,
    output logic [ID_W-1:0]           rsp_id,
    output logic [DATA_W-1:0]         rsp_data
);

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
    } rsp_state_t;

    rsp_state_t        rsp_d, rsp_q;
    logic [ID_W-1:0]   win_idx;
    lock_op_e          win_op;
    logic [ADDR_W-1:0] win_addr;
    logic [DATA_W-1:0] win_wdata;
    logic [DATA_W-1:0] win_old;
    logic              bus_busy;

    rr_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (grant),
        .gnt_idx (win_idx)
    );

    req_select #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_idx   (win_idx),
        .sel_op    (win_op),
        .sel_addr  (win_addr),
        .sel_wdata (win_wdata)
    );

    lock_store #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_en    (bus_busy),
        .op       (win_op),
        .addr     (win_addr),
        .wdata    (win_wdata),
        .old_data (win_old)
    );

    always_comb begin
        bus_busy = |grant;
        rsp_d    = rsp_q;
        rsp_d.valid = bus_busy;
        if (bus_busy) begin
            rsp_d.id   = win_idx;
            rsp_d.data = win_old;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_id    = rsp_q.id;
    assign rsp_data  = rsp_q.data;

    AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> rsp_valid); // R6
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> !rsp_valid); // R6
    AST_RSP_ID_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> ((($past(grant) >> rsp_id) & NUM_REQ'(1)) != '0)); // R6

endmodule

// File: tb/swap_lock_unit_test.sv
`timescale 1ns/1ps
module swap_lock_unit_test;

    localparam int N  = 4;
    localparam int L  = 8;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]    req_valid;
    logic [2*N-1:0]  req_op;
    logic [N*AW-1:0] req_addr;
    logic [N*DW-1:0] req_wdata;
    logic [N-1:0]    grant;
    logic            rsp_valid;
    logic [IW-1:0]   rsp_id;
    logic [DW-1:0]   rsp_data;

    swap_lock_unit #(.NUM_REQ(N), .NUM_LOCKS(L), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .grant(grant),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    // processor-side request registers
    bit       pv [N];
    bit [1:0] pop[N];
    int       pad[N];
    int       pwd[N];
    int       rl [N];
    bit       rg [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            req_valid[i]           = pv[i];
            req_op[2*i +: 2]       = pop[i];
            req_addr[AW*i +: AW]   = AW'(pad[i]);
            req_wdata[DW*i +: DW]  = DW'(pwd[i]);
        end
    end

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int       mem[L];
    int       ptr;
    bit       ev;
    int       eid, edat;
    bit [N-1:0] last_grant;

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(grant == '0, "R10 grant during reset", int'(grant), 0);
            chk(rsp_valid == 1'b0, "R10 rsp_valid during reset", int'(rsp_valid), 0);
            foreach (mem[j]) mem[j] = 0;
            ptr = N - 1;
            ev = 0;
            last_grant = '0;
        end else begin
            int win;
            bit [N-1:0] eg;
            chk(rsp_valid == ev, "R6 rsp_valid timing", int'(rsp_valid), int'(ev));
            if (ev && rsp_valid) begin
                chk(int'(rsp_id) == eid, "R6 rsp_id", int'(rsp_id), eid);
                chk(int'(rsp_data) == edat, "R1 rsp_data old value", int'(rsp_data), edat);
            end
            chk($countones(grant) <= 1, "R2 single grant", $countones(grant), 1);
            win = -1;
            for (int k = 1; k <= N; k++) begin
                int p;
                p = (ptr + k) % N;
                if (win < 0 && pv[p]) win = p;
            end
            eg = (win >= 0) ? (N'(1) << win) : '0;
            chk(grant == eg, "R3 round-robin grant", int'(grant), int'(eg));
            if (win >= 0) begin
                ev   = 1;
                eid  = win;
                edat = mem[pad[win]];
                if (pop[win] == 2'b01) mem[pad[win]] = pwd[win] & 8'hFF;
                else if (pop[win] == 2'b10) mem[pad[win]] = 1;
                ptr = win;
            end else begin
                ev = 0;
            end
            last_grant = grant;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        for (int i = 0; i < N; i++) if (last_grant[i]) pv[i] = 0;
        if (rsp_valid) begin
            rl[rsp_id] = int'(rsp_data);
            rg[rsp_id] = 1;
        end
    endtask

    task automatic issue(input int i, input bit [1:0] op, input int a, input int d);
        pv[i] = 1; pop[i] = op; pad[i] = a; pwd[i] = d; rg[i] = 0;
    endtask

    task automatic drain();
        bit busy;
        do begin
            step();
            busy = 0;
            for (int i = 0; i < N; i++) busy |= pv[i];
        end while (busy);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    int st[N], hold[N], wins[N];
    int owners;

    initial begin
        for (int i = 0; i < N; i++) begin
            pv[i] = 0; pop[i] = 0; pad[i] = 0; pwd[i] = 0; rl[i] = 0; rg[i] = 0;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R10: loads after reset read zero
        issue(0, 2'b00, 0, 0); issue(1, 2'b00, 3, 0);
        issue(2, 2'b00, 5, 0); issue(3, 2'b11, 7, 0);
        drain();
        for (int i = 0; i < N; i++) chk(rl[i] == 0, "R10 lock cleared by reset", rl[i], 0);

        // R5 / R1: all swap a free lock at once, requester 0 first
        for (int i = 0; i < N; i++) issue(i, 2'b10, 2, 0);
        drain();
        chk(rl[0] == 0, "R5 first swap wins", rl[0], 0);
        for (int i = 1; i < N; i++) chk(rl[i] == 1, "R5 later swap sees 1", rl[i], 1);

        // R7: release then swap again
        issue(2, 2'b01, 2, 0);
        drain();
        issue(3, 2'b10, 2, 0);
        drain();
        chk(rl[3] == 0, "R7 swap after release", rl[3], 0);

        // R8: store 5, loads return it and leave it
        issue(1, 2'b01, 1, 5);
        drain();
        issue(2, 2'b00, 1, 0); issue(0, 2'b11, 1, 0); issue(3, 2'b00, 1, 0);
        drain();
        chk(rl[2] == 5, "R8 load value", rl[2], 5);
        chk(rl[3] == 5, "R8 repeated load", rl[3], 5);
        chk(rl[0] == 5, "R8 code 11 loads", rl[0], 5);

        // R9: store and swap same lock, same cycle, two priority positions
        issue(3, 2'b10, 4, 0);
        drain();
        chk(rl[3] == 0, "R1 swap of free lock", rl[3], 0);
        issue(0, 2'b01, 4, 0); issue(1, 2'b10, 4, 0);
        drain();
        chk(rl[1] == 0, "R9 swap after store in order", rl[1], 0);
        issue(2, 2'b00, 4, 0);
        drain();
        chk(rl[2] == 1, "R9 swap granted second wins", rl[2], 1);
        issue(1, 2'b00, 7, 0);
        drain();
        issue(0, 2'b01, 4, 0); issue(2, 2'b10, 4, 0);
        drain();
        chk(rl[2] == 1, "R9 swap granted first", rl[2], 1);
        issue(3, 2'b00, 4, 0);
        drain();
        chk(rl[3] == 0, "R9 store granted second wins", rl[3], 0);

        // spinning contention on lock 6
        owners = 0;
        for (int i = 0; i < N; i++) begin
            wins[i] = 0; hold[i] = 0; st[i] = 1;
            issue(i, 2'b00, 6, 0);
        end
        for (int cyc = 0; cyc < 4000; cyc++) begin
            bit all_done;
            step();
            all_done = 1;
            for (int i = 0; i < N; i++) begin
                case (st[i])
                    1: if (rg[i]) begin
                        if (rl[i] == 0) begin issue(i, 2'b10, 6, 0); st[i] = 2; end
                        else issue(i, 2'b00, 6, 0);
                    end
                    2: if (rg[i]) begin
                        if (rl[i] == 0) begin
                            owners++;
                            chk(owners == 1, "R5 mutual exclusion", owners, 1);
                            hold[i] = 3; st[i] = 3; rg[i] = 0;
                        end else begin
                            issue(i, 2'b00, 6, 0); st[i] = 1;
                        end
                    end
                    3: begin
                        hold[i]--;
                        if (hold[i] == 0) begin issue(i, 2'b01, 6, 0); st[i] = 4; end
                    end
                    4: if (rg[i]) begin
                        owners--;
                        wins[i]++;
                        if (wins[i] < 2) begin issue(i, 2'b00, 6, 0); st[i] = 1; end
                        else begin st[i] = 5; rg[i] = 0; end
                    end
                    default: ;
                endcase
                if (st[i] != 5) all_done = 0;
            end
            if (all_done) break;
        end
        for (int i = 0; i < N; i++) chk(wins[i] == 2, "R4 every requester acquires", wins[i], 2);
        step();
        summary();
    end

endmodule